// File: doc/BRIEF.md
# Accumulator ALU with Selective Status Update

This block is the 8-bit arithmetic and logic unit of a small accumulator-style controller. Each cycle it may accept one decoded operation with its operands: the working register value, a file register value, an 8-bit literal, the three status flags, a destination bit and a 3-bit bit index. One cycle later it presents the result, where that result should be written (working register or file register), whether the next instruction should be skipped, and the new status flags.

The status flags are packed as carry in bit 0, half carry in bit 1 and zero in bit 2. Each operation updates only the flags it owns. Flags it does not own are passed from the status input to the status output unchanged. The surrounding controller can therefore always write the status output back without masking it.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low, and after it is released with no operation accepted, `out_valid`, `result`, `dest_file`, `skip` and `status_out` are all 0.
- R2: Operation codes on `op`: 0 add, 1 subtract, 2 increment, 3 increment-skip-zero, 4 decrement, 5 decrement-skip-zero, 6 AND, 7 OR, 8 XOR, 9 AND literal, 10 OR literal, 11 XOR literal, 12 complement, 13 swap nibbles, 14 rotate right through carry, 15 rotate left through carry, 16 move file, 17 clear working, 18 clear file, 19 bit set, 20 bit clear, 21 bit test skip-if-clear, 22 bit test skip-if-set. Any other code returns the file operand, with `dest_file` = `dest_t`, no skip and flags unchanged.
- R3: Add returns (F + W) mod 256. C is the carry out of bit 7, HC is the carry out of bit 3, and Z is set when the result is 0.
- R4: Subtract returns (F - W) mod 256, computed as F + ~W + 1. C is 1 when F >= W (no borrow). HC is 1 when F[3:0] >= W[3:0]. Z is set when the result is 0.
- R5: Increment, decrement, AND, OR, XOR (register and literal forms), complement of F, move file and both clears set Z to (result == 0) and pass C and HC through.
- R6: Increment-skip-zero and decrement-skip-zero change no flag and assert `skip` exactly when their result is 0.
- R7: Rotate right returns {C, F[7:1]} with new C = F[0]. Rotate left returns {F[6:0], C} with new C = F[7]. HC and Z pass through.
- R8: Swap returns {F[3:0], F[7:4]} and changes no flag.
- R9: Register-operand operations take `dest_file` from `dest_t`. The literal logic forms and clear working always give `dest_file` = 0. Clear file, bit set, bit clear and both bit tests always give `dest_file` = 1.
- R10: Bit set and bit clear return F with bit `bit_sel` forced to 1 or 0, and change no flag.
- R11: Bit test skip-if-clear asserts `skip` when F[`bit_sel`] is 0. Bit test skip-if-set asserts `skip` when it is 1. Both return F unchanged and change no flag.
- R12: `out_valid` is `in_valid` delayed by one cycle, and the results belong to the operation accepted in the previous cycle. When `in_valid` is low, `result`, `dest_file`, `skip` and `status_out` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code (R2) |
| w_in | input | 8 | Working register operand W |
| f_in | input | 8 | File register operand F |
| imm_in | input | 8 | Literal operand |
| dest_t | input | 1 | Destination bit for register operations, 1 = file |
| bit_sel | input | 3 | Bit index for bit operations |
| status_in | input | 3 | Flags in: {Z, HC, C} |
| out_valid | output | 1 | Result valid |
| result | output | 8 | Operation result |
| dest_file | output | 1 | 1 = write file register, 0 = write working register |
| skip | output | 1 | Skip the next instruction |
| status_out | output | 3 | Flags out: {Z, HC, C} |

## Verification
Directed vectors cover the arithmetic edges:
- 0xFF + 0x01 and 0x0F + 0x01 separate the carry out of bit 7 from the carry out of bit 3.
- Equal operands and F < W in subtract show the no-borrow carry convention and a zero result.
- Incrementing 0xFF and decrementing 0x01 show that the skip variants raise `skip` while leaving Z untouched.
- Rotates with carry both 0 and 1 confirm that the carry enters at the correct end.
- Bit tests at indices 0 and 7 catch a reversed index.

Several hundred random operations, including undefined codes, then mix every flag, destination and skip combination. A check after an idle cycle shows that the outputs hold their values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int ALU_W   = 8;
    localparam int IDX_W   = $clog2(ALU_W);
    localparam int ST_C    = 0;
    localparam int ST_HC   = 1;
    localparam int ST_Z    = 2;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_INC   = 5'd2,
        OP_INCSZ = 5'd3,
        OP_DEC   = 5'd4,
        OP_DECSZ = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_ANDI  = 5'd9,
        OP_ORI   = 5'd10,
        OP_XORI  = 5'd11,
        OP_COM   = 5'd12,
        OP_SWAP  = 5'd13,
        OP_RRC   = 5'd14,
        OP_RLC   = 5'd15,
        OP_MOVF  = 5'd16,
        OP_CLRW  = 5'd17,
        OP_CLRF  = 5'd18,
        OP_BSET  = 5'd19,
        OP_BCLR  = 5'd20,
        OP_BTSC  = 5'd21,
        OP_BTSS  = 5'd22
    } alu_op_e;

    typedef struct packed {
        logic             valid;
        logic [ALU_W-1:0] result;
        logic             dest_file;
        logic             skip;
        logic [2:0]       status;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             hcout
);
    localparam int NIB = WIDTH / 2;

    logic [WIDTH:0] full_sum;
    logic [NIB:0]   low_sum;

    always_comb begin
        full_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        low_sum  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        sum      = full_sum[WIDTH-1:0];
        cout     = full_sum[WIDTH];
        hcout    = low_sum[NIB];
    end
endmodule

// File: rtl/alu_bitmask.sv
module alu_bitmask #(
    parameter int WIDTH = 8,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic [IW-1:0]    idx,
    output logic [WIDTH-1:0] mask
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_dec
        assign mask[i] = (idx == IW'(i));
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [4:0]       op,
    input  logic [ALU_W-1:0] w_in,
    input  logic [ALU_W-1:0] f_in,
    input  logic [ALU_W-1:0] imm_in,
    input  logic             dest_t,
    input  logic [IDX_W-1:0] bit_sel,
    input  logic [2:0]       status_in,
    output logic             out_valid,
    output logic [ALU_W-1:0] result,
    output logic             dest_file,
    output logic             skip,
    output logic [2:0]       status_out
);
    localparam int NIB = ALU_W / 2;

    alu_state_t       state_d, state_q;
    logic [ALU_W-1:0] add_b_d, add_sum_d, mask_d;
    logic             add_cin_d, add_c_d, add_hc_d, bit_hit_d;
    logic [ALU_W-1:0] res_d;

    always_comb begin
        add_b_d   = w_in;
        add_cin_d = 1'b0;
        unique case (op)
            OP_SUB:            begin add_b_d = ~w_in;         add_cin_d = 1'b1; end
            OP_INC, OP_INCSZ:  begin add_b_d = '0;            add_cin_d = 1'b1; end
            OP_DEC, OP_DECSZ:  begin add_b_d = '1;            add_cin_d = 1'b0; end
            default:           begin add_b_d = w_in;          add_cin_d = 1'b0; end
        endcase
    end

    alu_addsub #(.WIDTH(ALU_W)) u_addsub (
        .a     (f_in),
        .b     (add_b_d),
        .cin   (add_cin_d),
        .sum   (add_sum_d),
        .cout  (add_c_d),
        .hcout (add_hc_d)
    );

    alu_bitmask #(.WIDTH(ALU_W)) u_mask (
        .idx  (bit_sel),
        .mask (mask_d)
    );

    assign bit_hit_d = |(f_in & mask_d);

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            res_d             = f_in;
            state_d.dest_file = dest_t;
            state_d.skip      = 1'b0;
            state_d.status    = status_in;
            unique case (op)
                OP_ADD, OP_SUB: begin
                    res_d                  = add_sum_d;
                    state_d.status[ST_C]   = add_c_d;
                    state_d.status[ST_HC]  = add_hc_d;
                end
                OP_INC, OP_DEC:            res_d = add_sum_d;
                OP_INCSZ, OP_DECSZ: begin
                    res_d        = add_sum_d;
                    state_d.skip = (add_sum_d == '0);
                end
                OP_AND:  res_d = w_in & f_in;
                OP_OR:   res_d = w_in | f_in;
                OP_XOR:  res_d = w_in ^ f_in;
                OP_ANDI: begin res_d = w_in & imm_in; state_d.dest_file = 1'b0; end
                OP_ORI:  begin res_d = w_in | imm_in; state_d.dest_file = 1'b0; end
                OP_XORI: begin res_d = w_in ^ imm_in; state_d.dest_file = 1'b0; end
                OP_COM:  res_d = ~f_in;
                OP_SWAP: res_d = {f_in[NIB-1:0], f_in[ALU_W-1:NIB]};
                OP_RRC: begin
                    res_d                = {status_in[ST_C], f_in[ALU_W-1:1]};
                    state_d.status[ST_C] = f_in[0];
                end
                OP_RLC: begin
                    res_d                = {f_in[ALU_W-2:0], status_in[ST_C]};
                    state_d.status[ST_C] = f_in[ALU_W-1];
                end
                OP_MOVF: res_d = f_in;
                OP_CLRW: begin res_d = '0; state_d.dest_file = 1'b0; end
                OP_CLRF: begin res_d = '0; state_d.dest_file = 1'b1; end
                OP_BSET: begin res_d = f_in | mask_d;  state_d.dest_file = 1'b1; end
                OP_BCLR: begin res_d = f_in & ~mask_d; state_d.dest_file = 1'b1; end
                OP_BTSC: begin state_d.skip = ~bit_hit_d; state_d.dest_file = 1'b1; end
                OP_BTSS: begin state_d.skip = bit_hit_d;  state_d.dest_file = 1'b1; end
                default: res_d = f_in;
            endcase
            unique case (op)
                OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR,
                OP_ANDI, OP_ORI, OP_XORI, OP_COM, OP_MOVF, OP_CLRW, OP_CLRF:
                    state_d.status[ST_Z] = (res_d == '0);
                default: ;
            endcase
            state_d.result = res_d;
        end else begin
            res_d = state_q.result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid  = state_q.valid;
    assign result     = state_q.result;
    assign dest_file  = state_q.dest_file;
    assign skip       = state_q.skip;
    assign status_out = state_q.status;

    assert_valid_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_valid) |-> $stable(result) && $stable(status_out));

    assert_add_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) == OP_ADD |-> result == ALU_W'($past(f_in) + $past(w_in)));

    assert_swap_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(op) == OP_SWAP |-> status_out == $past(status_in));

    assert_rotate_keeps_zh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(op) == OP_RRC || $past(op) == OP_RLC)
        |-> status_out[2:1] == $past(status_in[2:1]));

    assert_skipz_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(op) == OP_INCSZ || $past(op) == OP_DECSZ)
        |-> status_out == $past(status_in) && skip == (result == '0));

    assert_literal_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($past(op) == OP_ANDI || $past(op) == OP_ORI || $past(op) == OP_XORI)
        |-> !dest_file);
endmodule

// File: tb/alu_core_test.sv
`timescale 1ns/100ps
module alu_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] w_in = '0, f_in = '0, imm_in = '0;
    logic       dest_t = 1'b0;
    logic [2:0] bit_sel = '0;
    logic [2:0] status_in = '0;
    logic       out_valid, dest_file, skip;
    logic [7:0] result;
    logic [2:0] status_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .w_in(w_in), .f_in(f_in), .imm_in(imm_in), .dest_t(dest_t),
        .bit_sel(bit_sel), .status_in(status_in),
        .out_valid(out_valid), .result(result), .dest_file(dest_file),
        .skip(skip), .status_out(status_out)
    );

    // expected {dest_file, skip, status[2:0], result[7:0]}
    function automatic logic [12:0] model(input int o, input int w, input int f,
                                          input int im, input bit t, input int b,
                                          input logic [2:0] st);
        int r = f; bit d = t; bit sk = 0; bit c = st[0], h = st[1], z = st[2];
        bit zupd = 0;
        case (o)
            0:  begin r = (f + w) % 256; c = (f + w) > 255; h = ((f % 16) + (w % 16)) > 15; zupd = 1; end
            1:  begin r = (f - w + 256) % 256; c = f >= w; h = (f % 16) >= (w % 16); zupd = 1; end
            2:  begin r = (f + 1) % 256; zupd = 1; end
            3:  begin r = (f + 1) % 256; sk = (r == 0); end
            4:  begin r = (f + 255) % 256; zupd = 1; end
            5:  begin r = (f + 255) % 256; sk = (r == 0); end
            6:  begin r = w & f; zupd = 1; end
            7:  begin r = w | f; zupd = 1; end
            8:  begin r = w ^ f; zupd = 1; end
            9:  begin r = w & im; d = 0; zupd = 1; end
            10: begin r = w | im; d = 0; zupd = 1; end
            11: begin r = w ^ im; d = 0; zupd = 1; end
            12: begin r = 255 - f; zupd = 1; end
            13: r = (f % 16) * 16 + f / 16;
            14: begin r = f / 2 + (st[0] ? 128 : 0); c = f % 2; end
            15: begin r = (f * 2) % 256 + (st[0] ? 1 : 0); c = f >= 128; end
            16: zupd = 1;
            17: begin r = 0; d = 0; zupd = 1; end
            18: begin r = 0; d = 1; zupd = 1; end
            19: begin r = f | (1 << b); d = 1; end
            20: begin r = f & ~(1 << b) & 255; d = 1; end
            21: begin d = 1; sk = ((f >> b) % 2) == 0; end
            22: begin d = 1; sk = ((f >> b) % 2) == 1; end
            default: ;
        endcase
        if (zupd) z = (r == 0);
        return {d, sk, z, h, c, 8'(r)};
    endfunction

    function automatic string req_of(input int o);
        case (o)
            0: return "R3"; 1: return "R4";
            3, 5: return "R6"; 13: return "R8";
            14, 15: return "R7"; 9, 10, 11, 17, 18: return "R9";
            19, 20: return "R10"; 21, 22: return "R11";
            2, 4, 6, 7, 8, 12, 16: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic run(input int o, input int w, input int f, input int im,
                       input bit t, input int b, input logic [2:0] st);
        logic [12:0] exp_v, act;
        @(negedge clk);
        in_valid = 1'b1; op = 5'(o); w_in = 8'(w); f_in = 8'(f); imm_in = 8'(im);
        dest_t = t; bit_sel = 3'(b); status_in = st;
        exp_v = model(o, w, f, im, t, b, st);
        @(negedge clk);
        in_valid = 1'b0;
        act = {dest_file, skip, status_out, result};
        checks++;
        if (!out_valid || act !== exp_v) begin
            errors++;
            $display("FAIL %s op=%0d w=%h f=%h: actual v=%b %h expected v=1 %h",
                     req_of(o), o, w, f, out_valid, act, exp_v);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0] held;
        void'($urandom(32'd2229));
        repeat (3) @(negedge clk);
        checks++;
        if ({out_valid, result, dest_file, skip, status_out} !== '0) begin
            errors++;
            $display("FAIL R1: actual %h expected 0", {out_valid, result, dest_file, skip, status_out});
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 8'h00) begin
            errors++;
            $display("FAIL R1: actual v=%b r=%h expected 0 0", out_valid, result);
        end
        // R3 carry edges
        run(0, 8'h01, 8'hFF, 0, 1, 0, 3'b000);
        run(0, 8'h01, 8'h0F, 0, 0, 0, 3'b111);
        // R4 borrow edges
        run(1, 8'h55, 8'h55, 0, 1, 0, 3'b000);
        run(1, 8'h10, 8'h08, 0, 0, 0, 3'b111);
        // R6 skip on zero, flags untouched
        run(3, 0, 8'hFF, 0, 1, 0, 3'b010);
        run(5, 0, 8'h01, 0, 0, 0, 3'b001);
        run(5, 0, 8'h02, 0, 0, 0, 3'b100);
        // R7 carry enters both ends
        run(14, 0, 8'h01, 0, 1, 0, 3'b001);
        run(15, 0, 8'h80, 0, 1, 0, 3'b110);
        // R8, R9, R10, R11
        run(13, 0, 8'hA5, 0, 1, 0, 3'b101);
        run(9, 8'hF0, 8'hFF, 8'h0F, 1, 0, 3'b000);
        run(18, 0, 8'h33, 0, 0, 0, 3'b000);
        run(19, 0, 8'h00, 0, 0, 7, 3'b000);
        run(20, 0, 8'hFF, 0, 0, 0, 3'b111);
        run(21, 0, 8'h7F, 0, 0, 7, 3'b000);
        run(22, 0, 8'h01, 0, 0, 0, 3'b000);
        run(23, 8'h11, 8'h22, 0, 1, 0, 3'b011);
        // R12 hold while idle
        held = {dest_file, skip, status_out, result};
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || {dest_file, skip, status_out, result} !== held) begin
            errors++;
            $display("FAIL R12: actual v=%b %h expected v=0 %h", out_valid,
                     {dest_file, skip, status_out, result}, held);
        end
        for (int i = 0; i < 600; i++) begin
            run($urandom % 26, $urandom % 256, $urandom % 256, $urandom % 256,
                1'($urandom), $urandom % 8, 3'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule